// File: doc/BRIEF.md
# Reconfigurable Symmetric Line Crossbar

This block ties together a set of N single-bit signal lines through a non-blocking crossbar. No line is fixed as an input or an output. Each line offers its present value to the matrix, and each line can in turn be driven with the value of any other line. A source may feed as many destinations as needed. Every destination has its own multiplexer, so adding one route never disturbs any other route.

The routing is held in one source-select register per destination. Each register holds a source index and a valid bit. A narrow parallel write port changes one destination per cycle by connecting it to a source or by disconnecting it. All other routes keep carrying data during the change. Writes that are illegal are dropped, and a one-cycle error pulse reports them. A readback port returns the stored selection for any destination address.

A small controller records the result of the last write cycle. It has three named states: `CS_IDLE` (no write was taken), `CS_APPLIED` (a legal write was committed) and `CS_REJECTED` (a write was refused). In every state the transitions are the same. A legal write goes to `CS_APPLIED`, an illegal write goes to `CS_REJECTED`, and a cycle with no write returns to `CS_IDLE`.

Top module: `xbar_matrix`

## Requirements
- R1: While reset is asserted and right after it is released, every destination is disconnected: `line_drv` is all zeros, `line_out` is all zeros, `wr_err` is 0, and readback returns source 0 with valid 0.
- R2: A legal connect write (`wr_connect`=1) to destination d from source s takes effect at the clock edge that samples it. From then on `line_drv[d]`=1 and `line_out[d]` follows `line_in[s]` combinationally, in the same cycle that `line_in` changes.
- R3: One source may be selected by several destinations at once, and each of them carries that source's value.
- R4: A write changes only the addressed destination. The routing of every other destination is unchanged.
- R5: A disconnect write (`wr_connect`=0) to a destination below N clears that destination at the sampling edge, whatever value `wr_src` has.
- R6: When a destination receives several writes, the most recent one fixes its selection. Only one source ever drives a destination.
- R7: A connect write whose source index equals its destination index is ignored and leaves all routing unchanged. `wr_err` is 1 for exactly the cycle after the write.
- R8: A write whose destination index is N or above, or a connect write whose source index is N or above, is ignored in the same way and pulses `wr_err` for one cycle.
- R9: Readback has one cycle of latency. `rd_src`/`rd_valid` show the selection stored for `rd_addr` just before the edge that sampled `rd_addr`, so a write taken at that same edge is not yet visible. An address of N or above reads as source 0 with valid 0.
- R10: `wr_err` is 0 in any cycle that does not follow a rejected write, including idle cycles and cycles after accepted writes.
- R11: A destination that is not connected drives `line_out` 0, whatever the values on `line_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe for one routing update |
| wr_dst | input | IW | Destination line index being written |
| wr_src | input | IW | Source line index for a connect write |
| wr_connect | input | 1 | 1 = connect destination to source, 0 = disconnect |
| wr_err | output | 1 | One-cycle pulse after a rejected write |
| rd_addr | input | IW | Destination index to read back |
| rd_src | output | IW | Stored source index (one cycle later) |
| rd_valid | output | 1 | Stored connect bit (one cycle later) |
| line_in | input | N | Value each line presents to the matrix |
| line_out | output | N | Value routed onto each destination line |
| line_drv | output | N | Per-line flag: destination is currently driven |

IW is $clog2(N); the default N is 6.

## Verification
The data path has no register, so `line_out` must match `line_in` through the current routing in the same cycle that `line_in` changes. A routing write shows up on `line_out`/`line_drv` after the single edge that samples it. `wr_err` and the readback outputs are one register stage behind their inputs. The bench drives inputs one time unit after the falling edge. It advances its reference model at each rising edge and compares every output at the next falling edge, so each result is checked in the cycle it is due and never in the cycle before.

// File: rtl/xbar_pkg.sv
package xbar_pkg;

    // Result of the most recent configuration write cycle
    typedef enum logic [1:0] {
        CS_IDLE     = 2'd0,
        CS_APPLIED  = 2'd1,
        CS_REJECTED = 2'd2
    } cfg_state_e;

endpackage

// File: rtl/xbar_cfg_ctrl.sv
module xbar_cfg_ctrl
    import xbar_pkg::*;
#(
    parameter int N  = 6,
    parameter int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_dst,
    input  logic [IW-1:0] wr_src,
    input  logic          wr_connect,
    output logic          commit,
    output logic          wr_err
);

    localparam logic [IW:0] LINES = (IW+1)'(N);

    cfg_state_e state_q;
    cfg_state_e state_d;
    logic       dst_ok;
    logic       src_ok;
    logic       self_sel;
    logic       legal;

    // Classify the offered write
    always_comb begin
        dst_ok   = {1'b0, wr_dst} < LINES;
        src_ok   = {1'b0, wr_src} < LINES;
        self_sel = (wr_dst == wr_src);
        legal    = dst_ok && (!wr_connect || (src_ok && !self_sel));
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CS_IDLE, CS_APPLIED, CS_REJECTED: begin
                if (!wr_en) begin
                    state_d = CS_IDLE;
                end else if (legal) begin
                    state_d = CS_APPLIED;
                end else begin
                    state_d = CS_REJECTED;
                end
            end
            default: state_d = CS_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Outputs
    always_comb begin
        commit = wr_en && legal;
        wr_err = (state_q == CS_REJECTED);
    end

endmodule

// File: rtl/xbar_sel_bank.sv
module xbar_sel_bank #(
    parameter int N  = 6,
    parameter int IW = $clog2(N)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   commit,
    input  logic [IW-1:0]          wr_dst,
    input  logic [IW-1:0]          wr_src,
    input  logic                   wr_connect,
    input  logic [IW-1:0]          rd_addr,
    output logic [N-1:0][IW-1:0]   sel_src,
    output logic [N-1:0]           sel_vld,
    output logic [IW-1:0]          rd_src,
    output logic                   rd_valid
);

    localparam logic [IW:0] LINES = (IW+1)'(N);

    logic [N-1:0][IW-1:0] src_q;
    logic [N-1:0]         vld_q;

    // Per-destination source-select registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_q <= '0;
            vld_q <= '0;
        end else if (commit) begin
            for (int d = 0; d < N; d++) begin
                if (wr_dst == IW'(d)) begin
                    vld_q[d] <= wr_connect;
                    src_q[d] <= wr_connect ? wr_src : '0;
                end
            end
        end
    end

    // Readback register, captured from pre-update contents
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_src   <= '0;
            rd_valid <= 1'b0;
        end else if ({1'b0, rd_addr} < LINES) begin
            rd_src   <= src_q[rd_addr];
            rd_valid <= vld_q[rd_addr];
        end else begin
            rd_src   <= '0;
            rd_valid <= 1'b0;
        end
    end

    assign sel_src = src_q;
    assign sel_vld = vld_q;

endmodule

// File: rtl/xbar_mux_col.sv
module xbar_mux_col #(
    parameter int N  = 6,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  line_in,
    input  logic [IW-1:0] sel,
    input  logic          vld,
    output logic          out_bit
);

    // One mux level per destination; gated to 0 when undriven
    always_comb begin
        out_bit = 1'b0;
        for (int s = 0; s < N; s++) begin
            if (vld && (sel == IW'(s))) begin
                out_bit = line_in[s];
            end
        end
    end

endmodule

// File: rtl/xbar_matrix.sv
module xbar_matrix #(
    parameter int N  = 6,
    parameter int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_dst,
    input  logic [IW-1:0] wr_src,
    input  logic          wr_connect,
    output logic          wr_err,
    input  logic [IW-1:0] rd_addr,
    output logic [IW-1:0] rd_src,
    output logic          rd_valid,
    input  logic [N-1:0]  line_in,
    output logic [N-1:0]  line_out,
    output logic [N-1:0]  line_drv
);

    logic                 commit;
    logic [N-1:0][IW-1:0] sel_src;
    logic [N-1:0]         sel_vld;

    xbar_cfg_ctrl #(.N(N), .IW(IW)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_dst     (wr_dst),
        .wr_src     (wr_src),
        .wr_connect (wr_connect),
        .commit     (commit),
        .wr_err     (wr_err)
    );

    xbar_sel_bank #(.N(N), .IW(IW)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .commit     (commit),
        .wr_dst     (wr_dst),
        .wr_src     (wr_src),
        .wr_connect (wr_connect),
        .rd_addr    (rd_addr),
        .sel_src    (sel_src),
        .sel_vld    (sel_vld),
        .rd_src     (rd_src),
        .rd_valid   (rd_valid)
    );

    for (genvar d = 0; d < N; d++) begin : g_col
        xbar_mux_col #(.N(N), .IW(IW)) u_col (
            .line_in (line_in),
            .sel     (sel_src[d]),
            .vld     (sel_vld[d]),
            .out_bit (line_out[d])
        );
    end

    assign line_drv = sel_vld;

endmodule

// File: rtl/xbar_matrix_chk.sv
module xbar_matrix_chk #(
    parameter int N  = 6,
    parameter int IW = $clog2(N)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_en,
    input logic [IW-1:0] wr_dst,
    input logic [IW-1:0] wr_src,
    input logic          wr_connect,
    input logic          wr_err,
    input logic [IW-1:0] rd_addr,
    input logic          rd_valid,
    input logic [N-1:0]  line_out,
    input logic [N-1:0]  line_drv
);

    localparam logic [IW:0] LINES = (IW+1)'(N);

    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (line_drv == '0 && !wr_err));

    assert_connect_drives_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_connect && ({1'b0, wr_dst} < LINES) && ({1'b0, wr_src} < LINES)
         && (wr_dst != wr_src)) |=> line_drv[$past(wr_dst)]);

    assert_disconnect_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_connect && ({1'b0, wr_dst} < LINES)) |=> !line_drv[$past(wr_dst)]);

    assert_self_reject_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_connect && (wr_dst == wr_src)) |=> (wr_err && $stable(line_drv)));

    assert_range_reject_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && ({1'b0, wr_dst} >= LINES)) |=> (wr_err && $stable(line_drv)));

    assert_readback_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, rd_addr} < LINES) |=> (rd_valid == $past(line_drv[rd_addr])));

    assert_err_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> !wr_err);

    assert_undriven_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (line_out & ~line_drv) == '0);

endmodule

bind xbar_matrix xbar_matrix_chk #(.N(N), .IW(IW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_dst     (wr_dst),
    .wr_src     (wr_src),
    .wr_connect (wr_connect),
    .wr_err     (wr_err),
    .rd_addr    (rd_addr),
    .rd_valid   (rd_valid),
    .line_out   (line_out),
    .line_drv   (line_drv)
);

// File: tb/sim_xbar_matrix.sv
module sim_xbar_matrix;

    localparam int N  = 6;
    localparam int IW = $clog2(N);

    logic          clk = 1'b0;
    logic          rst_n;
    logic          wr_en;
    logic [IW-1:0] wr_dst;
    logic [IW-1:0] wr_src;
    logic          wr_connect;
    logic          wr_err;
    logic [IW-1:0] rd_addr;
    logic [IW-1:0] rd_src;
    logic          rd_valid;
    logic [N-1:0]  line_in;
    logic [N-1:0]  line_out;
    logic [N-1:0]  line_drv;

    always #2 clk = ~clk;

    xbar_matrix #(.N(N), .IW(IW)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_dst(wr_dst), .wr_src(wr_src),
        .wr_connect(wr_connect), .wr_err(wr_err), .rd_addr(rd_addr), .rd_src(rd_src),
        .rd_valid(rd_valid), .line_in(line_in), .line_out(line_out), .line_drv(line_drv)
    );

    int    checks = 0;
    int    errors = 0;
    string phase  = "R1";
    bit    done   = 1'b0;

    // Behavioural reference state
    int m_src[N];
    bit m_vld[N];
    bit m_err;
    int m_rd_src;
    bit m_rd_vld;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int d = 0; d < N; d++) begin
                m_src[d] = 0;
                m_vld[d] = 1'b0;
            end
            m_err    = 1'b0;
            m_rd_src = 0;
            m_rd_vld = 1'b0;
        end else begin
            bit ok;
            int dd;
            int ss;
            dd = int'(wr_dst);
            ss = int'(wr_src);
            if (int'(rd_addr) < N) begin
                m_rd_src = m_src[int'(rd_addr)];
                m_rd_vld = m_vld[int'(rd_addr)];
            end else begin
                m_rd_src = 0;
                m_rd_vld = 1'b0;
            end
            ok = (dd < N) && (!wr_connect || (ss < N && ss != dd));
            m_err = wr_en && !ok;
            if (wr_en && ok) begin
                m_vld[dd] = wr_connect;
                m_src[dd] = wr_connect ? ss : 0;
            end
        end
    end

    task automatic chk(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (!done) begin
            for (int d = 0; d < N; d++) begin
                int exp_o;
                exp_o = m_vld[d] ? int'(line_in[m_src[d]]) : 0;
                chk(m_vld[d] ? phase : "R11", $sformatf("line_out[%0d]", d), int'(line_out[d]), exp_o);
                chk(phase, $sformatf("line_drv[%0d]", d), int'(line_drv[d]), int'(m_vld[d]));
            end
            chk(m_err ? phase : "R10", "wr_err", int'(wr_err), int'(m_err));
            chk("R9", "rd_src", int'(rd_src), m_rd_src);
            chk("R9", "rd_valid", int'(rd_valid), int'(m_rd_vld));
        end
    end

    task automatic put(bit en, int dst, int src, bit conn, int ra);
        @(negedge clk);
        #1;
        wr_en      = en;
        wr_dst     = IW'(dst);
        wr_src     = IW'(src);
        wr_connect = conn;
        rd_addr    = IW'(ra);
        line_in    = N'($urandom);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) put(1'b0, 0, 0, 1'b0, i % 8);
    endtask

    initial begin
        rst_n = 1'b0; wr_en = 1'b0; wr_dst = '0; wr_src = '0;
        wr_connect = 1'b0; rd_addr = '0; line_in = '1;
        phase = "R1";
        repeat (3) @(negedge clk);
        #1 rst_n = 1'b1;
        idle(3);

        phase = "R2";
        put(1'b1, 2, 0, 1'b1, 2);
        idle(4);

        phase = "R3";
        put(1'b1, 3, 0, 1'b1, 3);
        put(1'b1, 4, 0, 1'b1, 4);
        put(1'b1, 5, 0, 1'b1, 5);
        idle(4);

        phase = "R4";
        put(1'b1, 3, 1, 1'b1, 3);
        idle(4);

        phase = "R6";
        put(1'b1, 1, 2, 1'b1, 1);
        put(1'b1, 1, 4, 1'b1, 1);
        idle(3);

        phase = "R5";
        put(1'b1, 4, 7, 1'b0, 4);
        idle(3);

        phase = "R7";
        put(1'b1, 5, 5, 1'b1, 5);
        idle(3);

        phase = "R8";
        put(1'b1, 6, 1, 1'b1, 6);
        put(1'b1, 2, 7, 1'b1, 2);
        put(1'b1, 7, 0, 1'b0, 7);
        idle(3);

        phase = "R9";
        for (int a = 0; a < 8; a++) put(1'b0, 0, 0, 1'b0, a);
        put(1'b1, 0, 3, 1'b1, 0);
        idle(2);

        phase = "R10";
        idle(6);

        phase = "R11";
        for (int d = 0; d < N; d++) put(1'b1, d, 0, 1'b0, d);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            #1 line_in = '1;
        end

        phase = "R4";
        for (int i = 0; i < 400; i++) begin
            put(($urandom % 3) != 0, $urandom % 8, $urandom % 8, ($urandom % 4) != 0, $urandom % 8);
        end
        idle(3);

        @(negedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL R10 watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule